// File: doc/BRIEF.md
# LED Brightness Register File with Guarded Mode Register

This block sits behind an I2C target engine, which turns bus activity into a byte stream and START/STOP pulses. In each write transaction, the first byte the engine delivers after START is a command byte. Its top three bits choose how the register pointer moves, and its low five bits choose the register. Data bytes that follow are written at the pointer. During a read transaction, the engine pulls bytes from the pointer.

The block holds sixteen 8-bit per-channel brightness values and one mode register. The mode register sets the slow PWM rate, enables the broadcast address, and can request a local reset. Writes to the mode register are guarded in three ways:
- The command byte must select the mode register exactly, with no auto-increment.
- The data byte must carry two fixed check bits.
- The new value is held pending and only takes effect at the next STOP.

The PWM generator and the bus bit engine are outside this block.

Stream rules: the write port never applies back-pressure. `wr_ready_o` is high from the first clock after reset, and a byte is taken on `wr_valid_i && wr_ready_o`. The read port offers `rd_valid_o` continuously from the first clock after reset. A byte counts as consumed on `rd_valid_o && rd_ready_i`, and `rd_data_o` always shows the register at the current pointer. START, STOP, a write handshake and a read handshake are expected in different cycles. If they coincide, the order of precedence is START, then STOP, then write, then read.

Top module: `lumen_regfile`

## Requirements
- R1: After reset, every brightness value is 00h, the mode register is 03h (slow_pwm_o=0, bcast_en_o=1), local_rst_o is 0, and both handshake flags rise on the first clock.
- R2: The first byte after start_i is the command. Bits [7:5] are the step code and bits [4:0] are the address. If the step code is neither 000 nor 100, the command and its data bytes are ignored and the pointer is left unchanged. Data bytes that arrive with no command are also ignored.
- R3: A data byte written while the pointer is at 00h–0Fh updates channel n, which appears on bright_o[8n+7:8n] in the cycle after the handshake.
- R4: Step code 000 keeps the pointer fixed. Step code 100 advances it by one after each written or read byte while it is inside 00h–0Fh, wrapping from 0Fh to 00h.
- R5: rd_data_o shows the brightness value at pointers 00h–0Fh, the mode register at 1Ah, and 00h elsewhere. Writes to unimplemented addresses change nothing.
- R6: The mode register can be written only after the command byte 1Ah exactly. A command of 9Ah, or an incrementing pointer, never changes it.
- R7: Only the first data byte after the 1Ah command counts. It is accepted only if bit 6 is 0 and bit 1 is 1; any other byte leaves the mode unchanged.
- R8: An accepted mode value is applied on the next stop_i. A start_i before that STOP discards it.
- R9: Mode bit 3 drives slow_pwm_o and mode bit 0 drives bcast_en_o.
- R10: If an applied mode value has bit 7 set, the STOP instead returns every register to its reset value, and local_rst_o is high for exactly one cycle.
- R11: wr_ready_o and rd_valid_o stay high once they have risen, until a hard reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | START or repeated START seen on the bus |
| stop_i | input | 1 | STOP seen on the bus |
| wr_valid_i | input | 1 | Write byte offered |
| wr_data_i | input | 8 | Write byte (command or data) |
| wr_ready_o | output | 1 | Write byte can be taken |
| rd_valid_o | output | 1 | Read byte available |
| rd_ready_i | input | 1 | Engine takes the read byte |
| rd_data_o | output | 8 | Register at the current pointer |
| bright_o | output | 128 | Sixteen packed brightness values, channel n at [8n+7:8n] |
| slow_pwm_o | output | 1 | Slow PWM rate selected |
| bcast_en_o | output | 1 | Respond to the broadcast address |
| local_rst_o | output | 1 | One-cycle pulse on a local reset |

## Verification
The bench targets the cases where this block is most likely to go wrong:
- **Pointer wrap from 0Fh to 00h**, on both writes and reads. A bad design would run into the hole above 0Fh, or stall on the last channel.
- **Increment attempts on the mode register**, including the 9Ah command. A bad design would let that write through.
- **Mode data with a wrong check bit, or a second mode byte in the same transaction.** A bad design would alter the slow or broadcast outputs.
- **A pending mode value cut off by a repeated START.** A bad design would apply the value early or keep it past the START.
- **The local-reset value.** A bad design would store the value instead of clearing the brightness bank, or stretch the pulse.

// File: rtl/lumen_pkg.sv
package lumen_pkg;
  localparam int CMD_W  = 8;
  localparam int ADDR_W = 5;
  localparam int STEP_W = CMD_W - ADDR_W;

  typedef enum logic [STEP_W-1:0] {
    STEP_HOLD = 3'b000,
    STEP_NEXT = 3'b100
  } step_mode_e;

  typedef struct packed {
    logic              ok;
    logic              step;
    logic              mode_sel;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/lumen_cmd_decode.sv
module lumen_cmd_decode
  import lumen_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MODE_ADDR = 5'h1A
) (
  input  logic [CMD_W-1:0] cmd_byte_i,
  output cmd_t             cmd_o
);
  logic [STEP_W-1:0] step_code;
  logic [ADDR_W-1:0] addr;

  assign step_code = cmd_byte_i[CMD_W-1 -: STEP_W];
  assign addr      = cmd_byte_i[ADDR_W-1:0];

  always_comb begin
    cmd_o.addr     = addr;
    cmd_o.ok       = (step_code == STEP_HOLD) || (step_code == STEP_NEXT);
    cmd_o.step     = (step_code == STEP_NEXT);
    cmd_o.mode_sel = (step_code == STEP_HOLD) && (addr == MODE_ADDR);
  end
endmodule

// File: rtl/lumen_ptr_unit.sv
module lumen_ptr_unit
  import lumen_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int IW     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_fire_i,
  input  logic              rd_fire_i,
  input  cmd_t              cmd_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              in_bank_o,
  output logic              bank_we_o,
  output logic              mode_byte_o
);
  logic              await_cmd_q;
  logic              cmd_ok_q;
  logic              step_q;
  logic              mode_sel_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              in_bank;
  logic              quiet;
  logic              data_byte;
  logic              advance;
  logic [IW-1:0]     idx_next;

  assign in_bank   = (ptr_q[ADDR_W-1:IW] == '0);
  assign quiet     = !start_i && !stop_i && !clr_i;
  assign data_byte = quiet && wr_fire_i && !await_cmd_q;
  assign bank_we_o = data_byte && cmd_ok_q && in_bank;
  assign mode_byte_o = data_byte && mode_sel_q;
  assign advance   = cmd_ok_q && step_q && in_bank &&
                     (bank_we_o || (quiet && !wr_fire_i && rd_fire_i));
  assign idx_next  = ptr_q[IW-1:0] + IW'(1);
  assign ptr_o     = ptr_q;
  assign in_bank_o = in_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      await_cmd_q <= 1'b0;
      cmd_ok_q    <= 1'b0;
      step_q      <= 1'b0;
      mode_sel_q  <= 1'b0;
      ptr_q       <= '0;
    end else if (clr_i) begin
      await_cmd_q <= 1'b0;
      cmd_ok_q    <= 1'b0;
      step_q      <= 1'b0;
      mode_sel_q  <= 1'b0;
      ptr_q       <= '0;
    end else if (start_i) begin
      await_cmd_q <= 1'b1;
      mode_sel_q  <= 1'b0;
    end else if (stop_i) begin
      await_cmd_q <= 1'b0;
      mode_sel_q  <= 1'b0;
    end else if (wr_fire_i && await_cmd_q) begin
      await_cmd_q <= 1'b0;
      cmd_ok_q    <= cmd_i.ok;
      mode_sel_q  <= cmd_i.mode_sel;
      if (cmd_i.ok) begin
        ptr_q  <= cmd_i.addr;
        step_q <= cmd_i.step;
      end
    end else begin
      if (wr_fire_i) mode_sel_q <= 1'b0;
      if (advance) ptr_q <= {{(ADDR_W-IW){1'b0}}, idx_next};
    end
  end

  AST_STEP_STAYS_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (ptr_q[ADDR_W-1:IW] == '0)); // R4
  AST_HOLD_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !wr_fire_i && rd_fire_i && !step_q) |=> $stable(ptr_q)); // R4
endmodule

// File: rtl/lumen_bright_bank.sv
module lumen_bright_bank #(
  parameter int NUM_CH = 16,
  parameter int DW     = 8,
  parameter int IW     = $clog2(NUM_CH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 we_i,
  input  logic [IW-1:0]        wr_idx_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic [IW-1:0]        rd_idx_i,
  output logic [DW-1:0]        rd_data_o,
  output logic [NUM_CH*DW-1:0] bright_o
);
  logic [DW-1:0] level_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  level_q[g] <= '0;
      else if (clr_i)                              level_q[g] <= '0;
      else if (we_i && (wr_idx_i == IW'(g)))       level_q[g] <= wr_data_i;
    end
    assign bright_o[g*DW +: DW] = level_q[g];
  end

  assign rd_data_o = level_q[rd_idx_i];

  AST_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && !clr_i) |=> $stable(bright_o)); // R3
endmodule

// File: rtl/lumen_mode_guard.sv
module lumen_mode_guard #(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] MODE_RST = 8'h03
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          mode_byte_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] mode_o,
  output logic          clr_now_o,
  output logic          local_rst_o
);
  localparam int CHK_ZERO = 6;
  localparam int CHK_ONE  = 1;
  localparam int LRST_BIT = DW - 1;

  logic [DW-1:0] mode_q;
  logic [DW-1:0] pend_q;
  logic          pend_v_q;
  logic          lrst_q;
  logic          accept;

  assign accept    = mode_byte_i && !data_i[CHK_ZERO] && data_i[CHK_ONE];
  assign clr_now_o = stop_i && !start_i && pend_v_q && pend_q[LRST_BIT];
  assign mode_o    = mode_q;
  assign local_rst_o = lrst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_RST;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      lrst_q   <= 1'b0;
    end else begin
      lrst_q <= clr_now_o;
      if (start_i) begin
        pend_v_q <= 1'b0;
      end else if (stop_i) begin
        pend_v_q <= 1'b0;
        if (pend_v_q) mode_q <= pend_q[LRST_BIT] ? MODE_RST : pend_q;
      end else if (accept) begin
        pend_q   <= data_i;
        pend_v_q <= 1'b1;
      end
    end
  end

  AST_MODE_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_i |=> $stable(mode_o)); // R8
  AST_MODE_CHECK_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_o[CHK_ZERO] && mode_o[CHK_ONE])); // R7
  AST_LRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    local_rst_o |=> !local_rst_o); // R10
endmodule

// File: rtl/lumen_regfile.sv
module lumen_regfile
  import lumen_pkg::*;
#(
  parameter int                NUM_CH    = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 5'h1A,
  parameter logic [CMD_W-1:0]  MODE_RST  = 8'h03
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    stop_i,
  input  logic                    wr_valid_i,
  input  logic [CMD_W-1:0]        wr_data_i,
  output logic                    wr_ready_o,
  output logic                    rd_valid_o,
  input  logic                    rd_ready_i,
  output logic [CMD_W-1:0]        rd_data_o,
  output logic [NUM_CH*CMD_W-1:0] bright_o,
  output logic                    slow_pwm_o,
  output logic                    bcast_en_o,
  output logic                    local_rst_o
);
  localparam int DW        = CMD_W;
  localparam int IW        = $clog2(NUM_CH);
  localparam int SLOW_BIT  = 3;
  localparam int BCAST_BIT = 0;

  logic              live_q;
  logic              wr_fire;
  logic              rd_fire;
  cmd_t              cmd;
  logic [ADDR_W-1:0] ptr;
  logic              in_bank;
  logic              bank_we;
  logic              mode_byte;
  logic              clr_now;
  logic [DW-1:0]     mode_val;
  logic [DW-1:0]     bank_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  assign wr_ready_o = live_q;
  assign rd_valid_o = live_q;
  assign wr_fire    = wr_valid_i && live_q;
  assign rd_fire    = rd_ready_i && live_q;

  lumen_cmd_decode #(.MODE_ADDR(MODE_ADDR)) u_decode (
    .cmd_byte_i (wr_data_i),
    .cmd_o      (cmd)
  );

  lumen_ptr_unit #(.NUM_CH(NUM_CH), .IW(IW)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_now),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .wr_fire_i   (wr_fire),
    .rd_fire_i   (rd_fire),
    .cmd_i       (cmd),
    .ptr_o       (ptr),
    .in_bank_o   (in_bank),
    .bank_we_o   (bank_we),
    .mode_byte_o (mode_byte)
  );

  lumen_bright_bank #(.NUM_CH(NUM_CH), .DW(DW), .IW(IW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_now),
    .we_i      (bank_we),
    .wr_idx_i  (ptr[IW-1:0]),
    .wr_data_i (wr_data_i),
    .rd_idx_i  (ptr[IW-1:0]),
    .rd_data_o (bank_rd),
    .bright_o  (bright_o)
  );

  lumen_mode_guard #(.DW(DW), .MODE_RST(MODE_RST)) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .mode_byte_i (mode_byte),
    .data_i      (wr_data_i),
    .mode_o      (mode_val),
    .clr_now_o   (clr_now),
    .local_rst_o (local_rst_o)
  );

  always_comb begin
    if (in_bank)                rd_data_o = bank_rd;
    else if (ptr == MODE_ADDR)  rd_data_o = mode_val;
    else                        rd_data_o = '0;
  end

  assign slow_pwm_o = mode_val[SLOW_BIT];
  assign bcast_en_o = mode_val[BCAST_BIT];

  AST_LIVE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |=> (rd_valid_o && wr_ready_o)); // R11
  AST_LRST_CLEARS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    local_rst_o |-> (bright_o == '0 && slow_pwm_o == 1'b0 && bcast_en_o == 1'b1)); // R10
endmodule

// File: tb/lumen_regfile_tb_top.sv
module lumen_regfile_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0, stop_i = 1'b0, wr_valid_i = 1'b0, rd_ready_i = 1'b0;
  logic [7:0]   wr_data_i = '0;
  logic         wr_ready_o, rd_valid_o, slow_pwm_o, bcast_en_o, local_rst_o;
  logic [7:0]   rd_data_o;
  logic [127:0] bright_o;

  always #4 clk = ~clk;

  lumen_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_ready_o(wr_ready_o),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o),
    .bright_o(bright_o), .slow_pwm_o(slow_pwm_o), .bcast_en_o(bcast_en_o),
    .local_rst_o(local_rst_o)
  );

  int checks = 0;
  int errors = 0;
  int mb[16];
  int m_mode, m_ptr, m_ok, m_step, m_await, m_msel, m_pend, m_pendv, m_lrst, m_live;

  task automatic chk(string tag, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 16; i++) mb[i] = 0;
    m_mode = 'h03; m_ptr = 0; m_ok = 0; m_step = 0;
    m_await = 0; m_msel = 0; m_pendv = 0;
  endtask

  task automatic model_step(bit s, bit p, bit wv, int wd, bit rr);
    if (!rst_n) begin
      model_clear(); m_pend = 0; m_lrst = 0; m_live = 0;
      return;
    end
    m_lrst = 0;
    if (s) begin
      m_await = 1; m_msel = 0; m_pendv = 0;
    end else if (p) begin
      m_await = 0; m_msel = 0;
      if (m_pendv) begin
        if (m_pend & 'h80) begin model_clear(); m_lrst = 1; end
        else m_mode = m_pend;
      end
      m_pendv = 0;
    end else if (wv && m_live) begin
      if (m_await) begin
        m_await = 0;
        m_ok = ((wd >> 5) == 0 || (wd >> 5) == 4);
        if (m_ok) begin m_ptr = wd & 31; m_step = ((wd >> 5) == 4); end
        m_msel = (wd == 'h1A);
      end else begin
        if (m_msel && !(wd & 'h40) && (wd & 'h02)) begin m_pend = wd; m_pendv = 1; end
        m_msel = 0;
        if (m_ok && m_ptr < 16) begin
          mb[m_ptr] = wd;
          if (m_step) m_ptr = (m_ptr + 1) % 16;
        end
      end
    end else if (rr && m_live) begin
      if (m_ok && m_step && m_ptr < 16) m_ptr = (m_ptr + 1) % 16;
    end
    m_live = 1;
  endtask

  function automatic int exp_rd();
    if (m_ptr < 16) return mb[m_ptr];
    if (m_ptr == 'h1A) return m_mode;
    return 0;
  endfunction

  task automatic compare_all();
    for (int i = 0; i < 16; i++) chk("R3 brightness", 128'(bright_o[i*8 +: 8]), 128'(mb[i] & 'hFF));
    chk("R9 slow", 128'(slow_pwm_o), 128'((m_mode >> 3) & 1));
    chk("R9 bcast", 128'(bcast_en_o), 128'(m_mode & 1));
    chk("R10 local reset", 128'(local_rst_o), 128'(m_lrst));
    chk("R11 wr_ready", 128'(wr_ready_o), 128'(m_live));
    chk("R11 rd_valid", 128'(rd_valid_o), 128'(m_live));
    chk("R5 rd_data", 128'(rd_data_o), 128'(exp_rd() & 'hFF));
  endtask

  task automatic tick(bit s, bit p, bit wv, logic [7:0] wd, bit rr);
    start_i = s; stop_i = p; wr_valid_i = wv; wr_data_i = wd; rd_ready_i = rr;
    @(posedge clk);
    model_step(s, p, wv, int'(wd), rr);
    @(negedge clk);
    start_i = 0; stop_i = 0; wr_valid_i = 0; rd_ready_i = 0;
    compare_all();
  endtask

  task automatic st();              tick(1, 0, 0, 8'h00, 0); endtask
  task automatic sp();              tick(0, 1, 0, 8'h00, 0); endtask
  task automatic wr(logic [7:0] b); tick(0, 0, 1, b, 0);     endtask
  task automatic rd();              tick(0, 0, 0, 8'h00, 1); endtask
  task automatic idle();            tick(0, 0, 0, 8'h00, 0); endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    idle(); idle();
    rst_n = 1'b1;
    idle();
    // R1 reset state
    chk("R1 bright", bright_o, '0);
    chk("R1 mode", 128'({slow_pwm_o, bcast_en_o}), 128'(2'b01));
    chk("R1 ready", 128'({wr_ready_o, rd_valid_o, local_rst_o}), 128'(3'b110));
    // R2 data with no command is ignored
    wr(8'h44); chk("R2 orphan data", bright_o, '0);
    // R3 fixed-pointer write, R4 pointer held
    st(); wr(8'h03); wr(8'h55); chk("R3 ch3", 128'(bright_o[31:24]), 128'(8'h55));
    wr(8'hAA); sp(); chk("R4 hold", 128'(bright_o[31:24]), 128'(8'hAA));
    // R4 increment and wrap
    st(); wr(8'h8E); wr(8'h11); wr(8'h22); wr(8'h33); sp();
    chk("R4 wrap", 128'({bright_o[119:112], bright_o[127:120], bright_o[7:0]}), 128'(24'h112233));
    // R2 illegal step code ignored
    st(); wr(8'h01); wr(8'h5A); sp();
    st(); wr(8'h25); wr(8'h77); sp();
    chk("R2 ignored write", 128'(bright_o[47:40]), 128'(8'h00));
    chk("R2 pointer kept", 128'(rd_data_o), 128'(8'h5A));
    // R5 reads with increment and wrap
    st(); wr(8'h8E); sp(); st();
    chk("R5 read 0E", 128'(rd_data_o), 128'(8'h11)); rd();
    chk("R5 read 0F", 128'(rd_data_o), 128'(8'h22)); rd();
    chk("R4 read wrap", 128'(rd_data_o), 128'(8'h33)); rd(); sp();
    // R5 unimplemented address
    st(); wr(8'h12); wr(8'h99); sp();
    chk("R5 hole", 128'(rd_data_o), 128'(8'h00));
    // R8 pending until STOP, R9 bits
    st(); wr(8'h1A); wr(8'h0A);
    chk("R8 not yet", 128'(slow_pwm_o), 128'(1'b0));
    sp();
    chk("R9 slow on", 128'({slow_pwm_o, bcast_en_o}), 128'(2'b10));
    chk("R5 mode read", 128'(rd_data_o), 128'(8'h0A));
    // R7 check bits and single byte
    st(); wr(8'h1A); wr(8'h48); sp();
    st(); wr(8'h1A); wr(8'h09); sp();
    st(); wr(8'h1A); wr(8'h40); wr(8'h03); sp();
    chk("R7 rejected", 128'(rd_data_o), 128'(8'h0A));
    // R6 increment never reaches mode
    st(); wr(8'h9A); wr(8'h0B); sp();
    st(); wr(8'h8F); wr(8'h01); wr(8'h02); sp();
    chk("R6 mode untouched", 128'({slow_pwm_o, bcast_en_o}), 128'(2'b10));
    chk("R6 wrap", 128'({bright_o[127:120], bright_o[7:0]}), 128'(16'h0102));
    // R8 START discards pending value
    st(); wr(8'h1A); wr(8'h0B); st(); sp();
    chk("R8 discarded", 128'(bcast_en_o), 128'(1'b0));
    // R10 local reset
    st(); wr(8'h1A); wr(8'h83); sp();
    chk("R10 pulse", 128'(local_rst_o), 128'(1'b1));
    chk("R10 cleared", bright_o, '0);
    idle();
    chk("R10 one cycle", 128'(local_rst_o), 128'(1'b0));
    chk("R10 mode default", 128'({slow_pwm_o, bcast_en_o}), 128'(2'b01));
    // R1 hard reset in mid-transaction
    st(); wr(8'h80); wr(8'hAB);
    rst_n = 1'b0; idle(); rst_n = 1'b1; idle();
    chk("R1 after reset", bright_o, '0);
    repeat (3) idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule